// File: doc/BRIEF.md
# Strided Descriptor Address Walker

This block turns a loaded descriptor into a stream of memory addresses for a structured object such as a vector, a matrix or a sub-block of a three-dimensional array. The descriptor holds a base address, an inclusive memory window (low and high address), a stride and a last value for each of three indexes, a total element count and a triangular-walk option. After a load the block presents one address per cycle through a valid/ready handshake. It advances three nested index counters on every accepted transfer.

Each address is the base plus the sum, over the three indexes, of stride times current index value. An address that falls outside the window is never presented. Instead the stream stops and a sticky error flag rises. When the requested number of addresses has been accepted, the block signals completion with a single-cycle pulse. A consumer such as a load/store unit takes addresses from the output and loads a new descriptor when it needs a new walk.

Top module: `desc_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `addr_valid`, `walk_done` and `walk_err` are all low.
- R2: The presented address equals base + stride_i·i + stride_j·j + stride_k·k, taken modulo 2^AW, where i, j and k are the current index values.
- R3: The indexes start at 0 after a load. i is the innermost index. When i equals its last value and a transfer is accepted, i returns to 0 and j advances. When j also equals its last value, j returns to 0 and k advances. When k also equals its last value, k returns to 0.
- R4: With `cfg_tri` set at load, the last value of i is the current value of j instead of `cfg_last_i`. This gives rows of 1, 2, 3, … elements.
- R5: Exactly `cfg_count` addresses are accepted per load. `walk_done` is high for exactly one cycle: the cycle after the final accepted transfer. If `cfg_count` is 0, no address is presented and `walk_done` is high in the cycle after the load.
- R6: The indexes advance only when `addr_valid` and `addr_ready` are both high. While `addr_ready` is low, `addr_valid` stays high and `addr_addr` holds its value.
- R7: If the current address is below `cfg_lo` or above `cfg_hi`, it is not presented: `addr_valid` stays low. `walk_err` rises in the next cycle, the stream stops, and `walk_done` is not pulsed.
- R8: `walk_err` stays high until the next load. A load clears it in the following cycle.
- R9: A load during an active walk abandons that walk and starts the new descriptor from index 0 in the next cycle. `cfg_*` values are captured only in a cycle where `load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture the cfg_* values and start a walk |
| cfg_base | input | AW | Base address |
| cfg_lo | input | AW | Lowest legal address (inclusive) |
| cfg_hi | input | AW | Highest legal address (inclusive) |
| cfg_stride_i | input | AW | Stride of index i |
| cfg_stride_j | input | AW | Stride of index j |
| cfg_stride_k | input | AW | Stride of index k |
| cfg_last_i | input | IW | Last value of index i |
| cfg_last_j | input | IW | Last value of index j |
| cfg_last_k | input | IW | Last value of index k |
| cfg_count | input | CW | Number of addresses to produce |
| cfg_tri | input | 1 | Triangular walk: last value of i follows j |
| addr_valid | output | 1 | An address is presented |
| addr_ready | input | 1 | Consumer accepts the address |
| addr_addr | output | AW | Presented address |
| walk_done | output | 1 | One-cycle pulse after the last transfer |
| walk_err | output | 1 | Sticky window violation flag |

## Verification
The bench builds the block with AW=16, IW=3 and CW=8. The three-bit index width keeps every index's last value at 7 or below, so walks of a few dozen elements reach wraps of i, j and k, including the wrap of the outermost index. A 16-bit address lets a large base and stride overflow within a few elements, which tests the modulo rule. The eight-bit count allows the zero-count case and walks longer than one full pass over the object. Stalls come from a pseudo-random ready pattern, and window violations are placed at both the low and the high edge.

// File: rtl/dag_pkg.sv
// Shared definitions for the descriptor address walker.
// Assumes exactly three nested index dimensions, i innermost.
package dag_pkg;
    localparam int DAG_DIMS = 3;

    typedef enum int {
        DIM_I = 0,
        DIM_J = 1,
        DIM_K = 2
    } dag_dim_e;
endpackage

// File: rtl/dag_index_stepper.sv
// Three nested index counters with inclusive last values.
// Dimension 0 is innermost. In triangular mode the last value of
// dimension 0 is the current value of dimension 1.
// Assumes clear and step are never needed together (clear wins).
module dag_index_stepper
    import dag_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          step,
    input  logic                          tri_mode,
    input  logic [DAG_DIMS-1:0][IW-1:0]   last,
    output logic [DAG_DIMS-1:0][IW-1:0]   idx
);
    logic [DAG_DIMS-1:0][IW-1:0] eff_last;
    logic [DAG_DIMS-1:0]         at_last;
    logic [DAG_DIMS:0]           carry;

    assign carry[0] = step;

    // Per-dimension last value, wrap detection and carry chain.
    for (genvar d = 0; d < DAG_DIMS; d++) begin : g_dim
        if (d == DIM_I) begin : g_inner
            assign eff_last[d] = tri_mode ? idx[DIM_J] : last[d];
        end else begin : g_outer
            assign eff_last[d] = last[d];
        end
        assign at_last[d]  = (idx[d] == eff_last[d]);
        assign carry[d+1]  = carry[d] & at_last[d];
    end

    // Index registers: restart on clear, advance where a carry arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx <= '0;
        end else begin
            for (int d = 0; d < DAG_DIMS; d++) begin
                if (carry[d]) begin
                    idx[d] <= at_last[d] ? '0 : idx[d] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dag_addr_calc.sv
// Combinational address: base plus the sum of stride times index,
// modulo 2^AW. Assumes AW > IW.
module dag_addr_calc
    import dag_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 3
) (
    input  logic [AW-1:0]                 base,
    input  logic [DAG_DIMS-1:0][AW-1:0]   stride,
    input  logic [DAG_DIMS-1:0][IW-1:0]   idx,
    output logic [AW-1:0]                 addr
);
    logic [DAG_DIMS-1:0][AW-1:0] term;

    // One product per dimension.
    for (genvar d = 0; d < DAG_DIMS; d++) begin : g_term
        assign term[d] = stride[d] * {{(AW-IW){1'b0}}, idx[d]};
    end

    // Sum the base and all products.
    always_comb begin
        addr = base;
        for (int d = 0; d < DAG_DIMS; d++) begin
            addr = addr + term[d];
        end
    end
endmodule

// File: rtl/dag_window.sv
// Flags an address outside the inclusive window [lo, hi].
module dag_window #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          outside
);
    // Unsigned comparison against both window edges.
    assign outside = (addr < lo) || (addr > hi);
endmodule

// File: rtl/desc_addr_gen.sv
// Descriptor-driven address walker. On load it captures a descriptor
// and then presents one address per cycle on a valid/ready handshake.
// It stops with a done pulse after cfg_count transfers, or with a
// sticky error on the first address outside the window.
// Assumes: load has priority over every other event.
module desc_addr_gen
    import dag_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 3,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_lo,
    input  logic [AW-1:0] cfg_hi,
    input  logic [AW-1:0] cfg_stride_i,
    input  logic [AW-1:0] cfg_stride_j,
    input  logic [AW-1:0] cfg_stride_k,
    input  logic [IW-1:0] cfg_last_i,
    input  logic [IW-1:0] cfg_last_j,
    input  logic [IW-1:0] cfg_last_k,
    input  logic [CW-1:0] cfg_count,
    input  logic          cfg_tri,
    output logic          addr_valid,
    input  logic          addr_ready,
    output logic [AW-1:0] addr_addr,
    output logic          walk_done,
    output logic          walk_err
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [AW-1:0]               d_base;
    logic [AW-1:0]               d_lo;
    logic [AW-1:0]               d_hi;
    logic [DAG_DIMS-1:0][AW-1:0] d_stride;
    logic [DAG_DIMS-1:0][IW-1:0] d_last;
    logic                        d_tri;

    logic [DAG_DIMS-1:0][IW-1:0] idx;
    logic [AW-1:0]               cur_addr;
    logic                        outside;
    logic                        running;
    logic [CW-1:0]               remaining;
    logic                        fire;

    // Descriptor capture on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_base   <= '0;
            d_lo     <= '0;
            d_hi     <= '0;
            d_stride <= '0;
            d_last   <= '0;
            d_tri    <= 1'b0;
        end else if (load) begin
            d_base          <= cfg_base;
            d_lo            <= cfg_lo;
            d_hi            <= cfg_hi;
            d_stride[DIM_I] <= cfg_stride_i;
            d_stride[DIM_J] <= cfg_stride_j;
            d_stride[DIM_K] <= cfg_stride_k;
            d_last[DIM_I]   <= cfg_last_i;
            d_last[DIM_J]   <= cfg_last_j;
            d_last[DIM_K]   <= cfg_last_k;
            d_tri           <= cfg_tri;
        end
    end

    dag_index_stepper #(.IW(IW)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load),
        .step     (fire),
        .tri_mode (d_tri),
        .last     (d_last),
        .idx      (idx)
    );

    dag_addr_calc #(.AW(AW), .IW(IW)) u_calc (
        .base   (d_base),
        .stride (d_stride),
        .idx    (idx),
        .addr   (cur_addr)
    );

    dag_window #(.AW(AW)) u_win (
        .addr    (cur_addr),
        .lo      (d_lo),
        .hi      (d_hi),
        .outside (outside)
    );

    // Handshake: present only an in-window address while running.
    assign addr_valid = running && !outside;
    assign addr_addr  = cur_addr;
    assign fire       = addr_valid && addr_ready && !load;

    // Walk control: element count, completion pulse, sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            remaining <= '0;
            walk_done <= 1'b0;
            walk_err  <= 1'b0;
        end else if (load) begin
            running   <= (cfg_count != '0);
            remaining <= cfg_count;
            walk_done <= (cfg_count == '0);
            walk_err  <= 1'b0;
        end else begin
            walk_done <= 1'b0;
            if (running && outside) begin
                running  <= 1'b0;
                walk_err <= 1'b1;
            end else if (fire) begin
                remaining <= remaining - ONE;
                if (remaining == ONE) begin
                    running   <= 1'b0;
                    walk_done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dag_checker.sv
// Protocol properties of the descriptor address walker, bound to
// every instance of desc_addr_gen.
module dag_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic          addr_valid,
    input logic          addr_ready,
    input logic [AW-1:0] addr_addr,
    input logic          walk_done,
    input logic          walk_err,
    input logic [AW-1:0] win_lo,
    input logic [AW-1:0] win_hi
);
    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (addr_addr >= win_lo && addr_addr <= win_hi)); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready && !load |=> addr_valid && $stable(addr_addr)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        walk_err && !load |=> walk_err); // R8

    AST_LOAD_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !walk_err); // R8

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        walk_err |-> !addr_valid && !walk_done); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done && !load |=> !walk_done); // R5

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> !addr_valid); // R5
endmodule

bind desc_addr_gen dag_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .addr_valid (addr_valid),
    .addr_ready (addr_ready),
    .addr_addr  (addr_addr),
    .walk_done  (walk_done),
    .walk_err   (walk_err),
    .win_lo     (d_lo),
    .win_hi     (d_hi)
);

// File: tb/desc_addr_gen_test.sv
// Bench: a behavioural reference model (address queue plus run/error/done
// flags) is advanced on each rising edge and compared on each falling edge.
module desc_addr_gen_test;
    localparam int AW = 16;
    localparam int IW = 3;
    localparam int CW = 8;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [AW-1:0] cfg_base = '0, cfg_lo = '0, cfg_hi = '0;
    logic [AW-1:0] cfg_stride_i = '0, cfg_stride_j = '0, cfg_stride_k = '0;
    logic [IW-1:0] cfg_last_i = '0, cfg_last_j = '0, cfg_last_k = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          cfg_tri = 1'b0;
    logic          rdy = 1'b1;
    logic          addr_valid;
    logic [AW-1:0] addr_addr;
    logic          walk_done;
    logic          walk_err;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    string cur_req = "R1";
    logic [7:0] lfsr = 8'hA5;

    // Reference model state.
    int  q[$];
    int  m_lo = 0, m_hi = 0;
    bit  m_run = 0, m_err = 0, m_done = 0;

    always #2 clk = ~clk;

    desc_addr_gen #(.AW(AW), .IW(IW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .load(load),
        .cfg_base(cfg_base), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cfg_stride_i(cfg_stride_i), .cfg_stride_j(cfg_stride_j),
        .cfg_stride_k(cfg_stride_k),
        .cfg_last_i(cfg_last_i), .cfg_last_j(cfg_last_j), .cfg_last_k(cfg_last_k),
        .cfg_count(cfg_count), .cfg_tri(cfg_tri),
        .addr_valid(addr_valid), .addr_ready(rdy), .addr_addr(addr_addr),
        .walk_done(walk_done), .walk_err(walk_err)
    );

    function automatic bit in_win(int a);
        return a >= m_lo && a <= m_hi;
    endfunction

    // Builds the expected address list of a whole walk.
    function automatic void build_walk();
        int i = 0, j = 0, k = 0, li;
        q.delete();
        for (int n = 0; n < int'(cfg_count); n++) begin
            q.push_back((int'(cfg_base) + int'(cfg_stride_i) * i
                        + int'(cfg_stride_j) * j + int'(cfg_stride_k) * k) & MASK);
            li = cfg_tri ? j : int'(cfg_last_i);
            if (i == li) begin
                i = 0;
                if (j == int'(cfg_last_j)) begin
                    j = 0;
                    k = (k == int'(cfg_last_k)) ? 0 : k + 1;
                end else j++;
            end else i++;
        end
    endfunction

    // Model advance at each rising edge from the stable inputs.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            q.delete(); m_run = 0; m_err = 0; m_done = 0;
        end else if (load) begin
            build_walk();
            m_lo = int'(cfg_lo); m_hi = int'(cfg_hi);
            m_err = 0;
            m_done = (cfg_count == 0);
            m_run = (cfg_count != 0);
        end else begin
            m_done = 0;
            if (m_run) begin
                if (!in_win(q[0])) begin
                    m_err = 1; m_run = 0;
                end else if (rdy) begin
                    void'(q.pop_front());
                    if (q.size() == 0) begin
                        m_run = 0; m_done = 1;
                    end
                end
            end
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare outputs against the model away from the active edge.
    always @(negedge clk) begin
        bit ev;
        ev = m_run && (q.size() > 0) && in_win(q.size() > 0 ? q[0] : 0);
        check("valid", int'(addr_valid), int'(ev));
        if (ev && addr_valid) check("addr", int'(addr_addr), q[0]);
        check("done", int'(walk_done), int'(m_done));
        check("err", int'(walk_err), int'(m_err));
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_load(int base, int lo, int hi, int si, int sj, int sk,
                           int li, int lj, int lk, int cnt, bit tri_m, string req);
        @(negedge clk);
        cur_req = req;
        cfg_base = AW'(base); cfg_lo = AW'(lo); cfg_hi = AW'(hi);
        cfg_stride_i = AW'(si); cfg_stride_j = AW'(sj); cfg_stride_k = AW'(sk);
        cfg_last_i = IW'(li); cfg_last_j = IW'(lj); cfg_last_k = IW'(lk);
        cfg_count = CW'(cnt); cfg_tri = tri_m;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        cfg_base = '1; cfg_count = '1;   // R9: ignored outside load
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic random_ready(int n);
        repeat (n) begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rdy = lfsr[0] | lfsr[2];
        end
        @(negedge clk);
        rdy = 1'b1;
    endtask

    initial begin
        // R1: reset state
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R2: one-dimensional vector
        do_load(100, 0, 65535, 3, 0, 0, 5, 0, 0, 6, 0, "R2");
        idle(10);
        // R2: modulo wrap of the address
        do_load(65530, 0, 65535, 3, 0, 0, 7, 0, 0, 5, 0, "R2");
        idle(8);
        // R3: full three-dimensional pass then outer wrap
        do_load(0, 0, 65535, 1, 10, 100, 2, 1, 1, 15, 0, "R3");
        idle(20);
        // R4: triangular walk
        do_load(0, 0, 65535, 1, 16, 0, 7, 3, 0, 10, 1, "R4");
        idle(14);
        // R6: stalls from a pseudo-random ready
        do_load(0, 0, 65535, 2, 20, 200, 3, 2, 1, 40, 0, "R6");
        random_ready(120);
        idle(4);
        // R5: zero count
        do_load(50, 0, 65535, 1, 0, 0, 3, 0, 0, 0, 0, "R5");
        idle(4);
        // R5: count longer than one pass
        do_load(0, 0, 65535, 1, 4, 0, 1, 1, 0, 9, 0, "R5");
        idle(12);
        // R7: high-edge violation mid-stream
        do_load(0, 0, 20, 4, 0, 0, 7, 0, 0, 8, 0, "R7");
        idle(12);
        // R8: error remains until reload, reload clears it
        cur_req = "R8";
        idle(6);
        do_load(0, 0, 65535, 4, 0, 0, 7, 0, 0, 3, 0, "R8");
        idle(6);
        // R7: low-edge violation on the first element
        do_load(10, 20, 100, 5, 0, 0, 7, 0, 0, 4, 0, "R7");
        idle(6);
        // R9: reload during an active walk with stalls
        do_load(1000, 0, 65535, 1, 8, 64, 7, 7, 7, 200, 0, "R9");
        random_ready(10);
        do_load(300, 0, 65535, 2, 0, 0, 3, 0, 0, 4, 0, "R9");
        idle(10);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule